// File: doc/BRIEF.md
# Per-Channel Epoch Word Inserter

Each input channel of a time-to-digital converter writes its measurements into its own memory. A shared coarse counter, 11 bits wide and clocked every 5 ns, covers only about 10.24 µs before it wraps. This block sits in front of one channel memory and extends that range. It keeps a private 28-bit epoch counter that steps whenever the coarse counter wraps, which gives a total range of roughly 45.8 minutes.

When the channel reports a hit, the block writes one time data word through a single memory write port. An epoch word goes into memory only when a hit arrives after the epoch value has changed, and then it is written just before that hit's time word. Wraps with no hit cost no memory bandwidth. A hit needs at most one epoch word per increment, however many hits follow.

An active-high counter clear input returns the epoch to zero. The first hit after reset or after a clear always carries an epoch word.

Top module: `epoch_inserter`

## Requirements
- R1: During and right after reset, `mem_we` is low and `mem_wdata` is zero.
- R2: A time word is `{1'b1, chan[6:0], 3'b000, fine[9:0], coarse[10:0]}`, with bit 31 set, the channel in bits 30:24, the fine time in bits 20:11 and the coarse time in bits 10:0. When no epoch word is due, it is written in the cycle after the hit is sampled.
- R3: The 28-bit epoch counter increases by one whenever the sampled coarse value is lower than the value in the previous cycle. The epoch counter wraps modulo 2^28, and nothing other than a wrap or a clear changes it.
- R4: An epoch word is `{3'b011, 1'b0, epoch[27:0]}`.
- R5: When an epoch word is due, it is written in the cycle after the hit is sampled, and the hit's time word follows in the next cycle.
- R6: Coarse wraps with no hit cause no writes. After an epoch word, later hits with no wrap in between write only time words.
- R7: A hit sampled in the same cycle as a wrap gets an epoch word that carries the already incremented value.
- R8: The first hit after reset writes an epoch word with value 0 before its time word.
- R9: While `cnt_clear` is high, the epoch is set to zero, a held time word is discarded, and any hit is ignored. No write appears in the following cycle, and the next hit writes an epoch word.
- R10: A hit sampled in the cycle in which a held time word is written is ignored.
- R11: A wrap that occurs during the held-word cycle makes the next hit write a fresh epoch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clear | input | 1 | Counter clear, active high |
| coarse | input | 11 | Shared free-running coarse counter |
| hit | input | 1 | Hit strobe, one cycle per hit |
| fine | input | 10 | Fine time of the hit |
| chan | input | 7 | Channel number placed in the time word |
| mem_we | output | 1 | Channel memory write enable |
| mem_wdata | output | 32 | Channel memory write data |

## Verification
A hit can be sampled in the same cycle as a coarse wrap. The bench provokes this by presenting 2047 and then 0 on the coarse input, with the hit strobe raised in the cycle that shows 0. The result is judged by checking that the epoch word carries the incremented value and that the time word that follows carries coarse time 0. A second overlap, a wrap during the held-word cycle, is produced by lowering the coarse value in that cycle. The bench then checks that the next hit writes a new epoch word.

// File: rtl/epoch_inserter.sv
module epoch_inserter #(
  parameter int COARSE_W = 11,
  parameter int EPOCH_W  = 28,
  parameter int FINE_W   = 10,
  parameter int CHAN_W   = 7,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_clear,
  input  logic [COARSE_W-1:0] coarse,
  input  logic                hit,
  input  logic [FINE_W-1:0]   fine,
  input  logic [CHAN_W-1:0]   chan,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_wdata
);
  localparam int TPAD_W = WORD_W - 1 - CHAN_W - FINE_W - COARSE_W;
  localparam int EPAD_W = WORD_W - 3 - EPOCH_W;

  logic [COARSE_W-1:0] coarse_q;
  logic [EPOCH_W-1:0]  epoch_q;
  logic                dirty_q;
  logic                hold_q;
  logic [WORD_W-1:0]   held_q;

  wire                wrap       = coarse < coarse_q;
  wire [EPOCH_W-1:0]  epoch_now  = epoch_q + EPOCH_W'(wrap);
  wire                need_epoch = dirty_q | wrap;
  wire [WORD_W-1:0]   time_word  = {1'b1, chan, {TPAD_W{1'b0}}, fine, coarse};
  wire [WORD_W-1:0]   epoch_word = {3'b011, {EPAD_W{1'b0}}, epoch_now};
  wire                is_epoch   = mem_we && mem_wdata[WORD_W-1 -: 3] == 3'b011;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q  <= '0;
      epoch_q   <= '0;
      dirty_q   <= 1'b1;
      hold_q    <= 1'b0;
      held_q    <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      coarse_q <= coarse;
      mem_we   <= 1'b0;
      hold_q   <= 1'b0;
      if (cnt_clear) begin
        epoch_q <= '0;
        dirty_q <= 1'b1;
      end else begin
        epoch_q <= epoch_now;
        if (wrap) dirty_q <= 1'b1;
        if (hold_q) begin
          mem_we    <= 1'b1;
          mem_wdata <= held_q;
        end else if (hit) begin
          mem_we <= 1'b1;
          if (need_epoch) begin
            mem_wdata <= epoch_word;
            held_q    <= time_word;
            hold_q    <= 1'b1;
            dirty_q   <= 1'b0;
          end else begin
            mem_wdata <= time_word;
          end
        end
      end
    end
  end

  assert_epoch_then_time_R5: assert property (@(posedge clk) disable iff (rst)
    (is_epoch && !cnt_clear) |=> (mem_we && mem_wdata[WORD_W-1]));

  assert_single_epoch_R6: assert property (@(posedge clk) disable iff (rst)
    is_epoch |=> !is_epoch);

  assert_epoch_source_R3: assert property (@(posedge clk) disable iff (rst)
    (epoch_q != $past(epoch_q)) |-> ($past(wrap) || $past(cnt_clear)));

  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> !mem_we);
endmodule

// File: tb/test_epoch_inserter.sv
`timescale 1ns/1ps
module test_epoch_inserter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_clear = 1'b0;
  logic [10:0] coarse = '0;
  logic        hit = 1'b0;
  logic [9:0]  fine = '0;
  logic [6:0]  chan = '0;
  logic        mem_we;
  logic [31:0] mem_wdata;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epoch_inserter i_epoch_inserter (
    .clk(clk), .rst(rst), .cnt_clear(cnt_clear), .coarse(coarse), .hit(hit),
    .fine(fine), .chan(chan), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic [31:0] ew(input logic [27:0] e);
    return {3'b011, 1'b0, e};
  endfunction

  function automatic logic [31:0] tw(input logic [6:0] ch, input logic [9:0] f,
                                     input logic [10:0] c);
    return {1'b1, ch, 3'b000, f, c};
  endfunction

  task automatic step(input logic h, input logic clr, input logic [10:0] c,
                      input logic [9:0] f = '0, input logic [6:0] ch = '0);
    hit = h; cnt_clear = clr; coarse = c; fine = f; chan = ch;
    @(posedge clk); #1;
    hit = 1'b0; cnt_clear = 1'b0;
  endtask

  task automatic chk(input string req, input logic we_exp, input logic [31:0] d_exp);
    checks++;
    if (mem_we !== we_exp || (we_exp && mem_wdata !== d_exp)) begin
      fails++;
      $display("FAIL %s: we=%b data=%h expected we=%b data=%h",
               req, mem_we, mem_wdata, we_exp, d_exp);
    end
  endtask

  task automatic t_reset;
    repeat (3) begin @(posedge clk); #1; end
    chk("R1", 1'b0, '0);
    checks++;
    if (mem_wdata !== 32'h0) begin
      fails++;
      $display("FAIL R1: data=%h expected data=%h", mem_wdata, 32'h0);
    end
    rst = 1'b0;
    step(0, 0, 11'd4);
    chk("R1", 1'b0, '0);
  endtask

  task automatic t_first_hit;
    step(1, 0, 11'd5, 10'd100, 7'd3);
    chk("R8 R4", 1'b1, ew(28'd0));
    step(0, 0, 11'd6);
    chk("R5 R2", 1'b1, tw(7'd3, 10'd100, 11'd5));
    step(0, 0, 11'd7);
    chk("R5", 1'b0, '0);
    step(1, 0, 11'd8, 10'd7, 7'd3);
    chk("R6 R2", 1'b1, tw(7'd3, 10'd7, 11'd8));
  endtask

  task automatic t_silent_wraps;
    step(0, 0, 11'd2047); chk("R6", 1'b0, '0);
    step(0, 0, 11'd0);    chk("R6", 1'b0, '0);
    step(0, 0, 11'd2047); chk("R6", 1'b0, '0);
    step(0, 0, 11'd0);    chk("R6", 1'b0, '0);
    step(0, 0, 11'd2047); chk("R6", 1'b0, '0);
    step(0, 0, 11'd1);    chk("R3", 1'b0, '0);
    step(1, 0, 11'd10, 10'd55, 7'd9);
    chk("R3 R5", 1'b1, ew(28'd3));
    step(0, 0, 11'd11);
    chk("R5", 1'b1, tw(7'd9, 10'd55, 11'd10));
    step(1, 0, 11'd12, 10'd1, 7'd9);
    chk("R6", 1'b1, tw(7'd9, 10'd1, 11'd12));
  endtask

  task automatic t_hit_on_wrap;
    step(0, 0, 11'd2047);
    step(1, 0, 11'd0, 10'd200, 7'd2);
    chk("R7", 1'b1, ew(28'd4));
    step(0, 0, 11'd1);
    chk("R7", 1'b1, tw(7'd2, 10'd200, 11'd0));
  endtask

  task automatic t_hold_ignore;
    step(0, 0, 11'd2047);
    step(0, 0, 11'd0);
    step(1, 0, 11'd3, 10'd11, 7'd1);
    chk("R10", 1'b1, ew(28'd5));
    step(1, 0, 11'd4, 10'd22, 7'd1);
    chk("R10", 1'b1, tw(7'd1, 10'd11, 11'd3));
    step(0, 0, 11'd5);
    chk("R10", 1'b0, '0);
  endtask

  task automatic t_wrap_in_hold;
    step(0, 0, 11'd2047);
    step(0, 0, 11'd0);
    step(1, 0, 11'd1, 10'd33, 7'd4);
    chk("R11", 1'b1, ew(28'd6));
    step(0, 0, 11'd0);
    chk("R11", 1'b1, tw(7'd4, 10'd33, 11'd1));
    step(1, 0, 11'd2, 10'd44, 7'd4);
    chk("R11", 1'b1, ew(28'd7));
    step(0, 0, 11'd3);
    chk("R11", 1'b1, tw(7'd4, 10'd44, 11'd2));
  endtask

  task automatic t_clear;
    step(1, 1, 11'd4, 10'd5, 7'd4);
    chk("R9", 1'b0, '0);
    step(1, 0, 11'd5, 10'd6, 7'd4);
    chk("R9", 1'b1, ew(28'd0));
    step(0, 0, 11'd6);
    chk("R9", 1'b1, tw(7'd4, 10'd6, 11'd5));
    step(0, 0, 11'd2047);
    step(0, 0, 11'd0);
    step(1, 0, 11'd1, 10'd9, 7'd4);
    chk("R9", 1'b1, ew(28'd1));
    step(0, 1, 11'd2);
    chk("R9", 1'b0, '0);
    step(0, 0, 11'd3);
    chk("R9", 1'b0, '0);
    step(1, 0, 11'd4, 10'd8, 7'd4);
    chk("R9", 1'b1, ew(28'd0));
    step(0, 0, 11'd5);
    chk("R9", 1'b1, tw(7'd4, 10'd8, 11'd4));
  endtask

  initial begin
    t_reset();
    t_first_hit();
    t_silent_wraps();
    t_hit_on_wrap();
    t_hold_ignore();
    t_wrap_in_hold();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule